// File: doc/BRIEF.md
# Dual-Mode I2C Bus Clock Generator

This block produces the serial clock for an I2C master from the peripheral clock. Two configuration inputs supply an 11-bit clock-select value. The low five bits sit in the clock control input, and the upper six bits come from an extension input. The same control input carries an enable bit and a fast-mode bit. A small frequency code, equal to floor(pclk / 20 MHz) + 1, sets how many consecutive peripheral clocks a bus level must hold before the input filters accept it.

When enabled, the generator pulls SCL low for the low phase and then releases the line. It waits until the filtered SCL is actually high, which lets a slave stretch the clock. Only then does it count the high phase. The byte engine receives four single-cycle strobes: the start of the low phase, a mid-low point for changing SDA, the start of the counted high phase, and a mid-high sampling point. Clearing the enable bit releases the line and resets the sequencer at once. The configuration is expected to stay stable while the block is enabled.

There is no streaming data path. All pins are plain control and status levels, and the strobes are single-cycle pulses that carry no back-pressure.

Top module: `scl_clk_gen`

## Requirements
- R1: After reset, and on every cycle that follows a cycle with enable (clk_ctl[5]) at 0, scl_pull_low and all four strobes are 0. After reset, scl_level and sda_level read 1.
- R2: In standard mode (clk_ctl[6]=0) with freq_sel of 2 or more, the divisor is N = {clk_ext, clk_ctl[4:0]} + 1. The nominal low length is N+1 cycles and the nominal high length is N+1 cycles.
- R3: In standard mode with freq_sel of 0 or 1, clk_ext is ignored and N = clk_ctl[4:0] + 65. Both nominal lengths are N+1.
- R4: In fast mode (clk_ctl[6]=1), N = {clk_ext, clk_ctl[4:0]} + 1. The nominal low length is N+1 and the nominal high length is floor(N/2)+1, in both frequency ranges.
- R5: scl_pull_low stays high for max(low length, F+2) cycles, where F is freq_sel (0 counts as 1). The low phase ends only once the filtered SCL reads low.
- R6: With SCL looped back and no stretching, the line is released for F+2+high length cycles.
- R7: high_start is asserted F+2+S cycles after release, where S is the number of extra cycles a slave holds SCL low. The released time grows by S.
- R8: A level change on sda_in (or scl_in) appears on sda_level (scl_level) exactly F+1 clocks after it is applied, once it has held for F clocks. A pulse shorter than F clocks never appears.
- R9: low_start is asserted in the first cycle of scl_pull_low. drive_pt is asserted once per low phase, at cycle index floor(low length / 2) counted from 0.
- R10: Clearing enable in the middle of a phase releases SCL on the next cycle. Setting it again starts a full, fresh low phase, with low_start on the following cycle.
- R11: sample_pt is asserted once per high phase, floor(high length / 2) cycles after high_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_ctl | input | 7 | [4:0] clock-select low bits, [5] enable, [6] fast mode |
| clk_ext | input | 6 | Clock-select bits [10:5] |
| freq_sel | input | 4 | Frequency code; filter stability length |
| scl_in | input | 1 | Sensed SCL bus level |
| sda_in | input | 1 | Sensed SDA bus level |
| scl_pull_low | output | 1 | 1 drives SCL low (open drain) |
| scl_level | output | 1 | Filtered SCL |
| sda_level | output | 1 | Filtered SDA |
| low_start | output | 1 | First cycle of the low phase |
| drive_pt | output | 1 | Mid-low point for SDA changes |
| high_start | output | 1 | First counted high cycle |
| sample_pt | output | 1 | Mid-high sampling point |

## Verification
A wrong divisor mapping or a wrong mode decode shows up within the first SCL period after enable, as a pull-low or release width that differs from the requirement. Checks therefore cover both modes and both frequency ranges. A sequencer that starts counting the high phase without waiting for the line, or a filter with the wrong length, moves high_start and sample_pt by a fixed number of cycles in every period. Stretched periods and short SDA pulses expose these errors directly. A sequencer state that survives disable would show as a missing or late low_start on the cycle right after re-enable.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;
endpackage

// File: rtl/scl_line_filter.sv
module scl_line_filter #(
  parameter int FREQ_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  input  logic [FREQ_W-1:0] thresh,
  output logic              level
);
  logic              sync_q;
  logic              lvl_q;
  logic [FREQ_W-1:0] run_q;
  logic [FREQ_W-1:0] thr;

  // a zero code behaves as one
  assign thr = (thresh == '0) ? {{(FREQ_W-1){1'b0}}, 1'b1} : thresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b1;
      lvl_q  <= 1'b1;
      run_q  <= '0;
    end else begin
      sync_q <= line_in;
      if (sync_q != lvl_q) begin
        if (run_q == thr - 1'b1) begin
          lvl_q <= sync_q;
          run_q <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  assign level = lvl_q;
endmodule

// File: rtl/scl_div_map.sv
module scl_div_map #(
  parameter int LO_W        = 5,
  parameter int HI_W        = 6,
  parameter int FREQ_W      = 4,
  parameter int LOWF_OFFSET = 65,
  localparam int CNT_W      = LO_W + HI_W + 1
) (
  input  logic              fast,
  input  logic [LO_W-1:0]   cs_lo,
  input  logic [HI_W-1:0]   cs_hi,
  input  logic [FREQ_W-1:0] freq,
  output logic [CNT_W-1:0]  low_len,
  output logic [CNT_W-1:0]  high_len
);
  logic             low_range;
  logic [CNT_W-1:0] div_n;

  assign low_range = (freq <= {{(FREQ_W-1){1'b0}}, 1'b1});

  always_comb begin
    if (!fast && low_range) begin
      div_n = CNT_W'(cs_lo) + CNT_W'(LOWF_OFFSET);
    end else begin
      div_n = CNT_W'({cs_hi, cs_lo}) + 1'b1;
    end
    low_len  = div_n + 1'b1;
    high_len = fast ? ((div_n >> 1) + 1'b1) : (div_n + 1'b1);
  end
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] low_len,
  input  logic [CNT_W-1:0] high_len,
  input  logic             line_high,
  output logic             pull_low,
  output logic             low_start,
  output logic             drive_pt,
  output logic             high_start,
  output logic             sample_pt
);
  phase_e           ph_q;
  logic [CNT_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      idx_q <= '0;
    end else if (!en) begin
      ph_q  <= PH_IDLE;
      idx_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          ph_q  <= PH_LOW;
          idx_q <= '0;
        end
        PH_LOW: begin
          if (idx_q >= low_len - 1'b1 && !line_high) begin
            ph_q  <= PH_WAIT;
            idx_q <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        PH_WAIT: begin
          if (line_high) begin
            ph_q  <= PH_HIGH;
            idx_q <= '0;
          end
        end
        PH_HIGH: begin
          if (idx_q >= high_len - 1'b1) begin
            ph_q  <= PH_LOW;
            idx_q <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: begin
          ph_q  <= PH_IDLE;
          idx_q <= '0;
        end
      endcase
    end
  end

  assign pull_low   = (ph_q == PH_LOW);
  assign low_start  = (ph_q == PH_LOW)  && (idx_q == '0);
  assign drive_pt   = (ph_q == PH_LOW)  && (idx_q == (low_len >> 1));
  assign high_start = (ph_q == PH_HIGH) && (idx_q == '0);
  assign sample_pt  = (ph_q == PH_HIGH) && (idx_q == (high_len >> 1));
endmodule

// File: rtl/scl_clk_gen.sv
module scl_clk_gen #(
  parameter int LO_W        = 5,
  parameter int HI_W        = 6,
  parameter int FREQ_W      = 4,
  parameter int LOWF_OFFSET = 65
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LO_W+1:0]   clk_ctl,
  input  logic [HI_W-1:0]   clk_ext,
  input  logic [FREQ_W-1:0] freq_sel,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_pull_low,
  output logic              scl_level,
  output logic              sda_level,
  output logic              low_start,
  output logic              drive_pt,
  output logic              high_start,
  output logic              sample_pt
);
  localparam int CNT_W   = LO_W + HI_W + 1;
  localparam int EN_BIT  = LO_W;
  localparam int FM_BIT  = LO_W + 1;
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_lines;
  logic [N_LINES-1:0] flt_lines;
  logic [CNT_W-1:0]   low_len;
  logic [CNT_W-1:0]   high_len;

  assign raw_lines = {sda_in, scl_in};

  for (genvar g = 0; g < N_LINES; g++) begin : g_flt
    scl_line_filter #(.FREQ_W(FREQ_W)) u_flt (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_in(raw_lines[g]),
      .thresh (freq_sel),
      .level  (flt_lines[g])
    );
  end

  assign scl_level = flt_lines[0];
  assign sda_level = flt_lines[1];

  scl_div_map #(
    .LO_W(LO_W), .HI_W(HI_W), .FREQ_W(FREQ_W), .LOWF_OFFSET(LOWF_OFFSET)
  ) u_map (
    .fast    (clk_ctl[FM_BIT]),
    .cs_lo   (clk_ctl[LO_W-1:0]),
    .cs_hi   (clk_ext),
    .freq    (freq_sel),
    .low_len (low_len),
    .high_len(high_len)
  );

  scl_phase_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (clk_ctl[EN_BIT]),
    .low_len   (low_len),
    .high_len  (high_len),
    .line_high (scl_level),
    .pull_low  (scl_pull_low),
    .low_start (low_start),
    .drive_pt  (drive_pt),
    .high_start(high_start),
    .sample_pt (sample_pt)
  );
endmodule

// File: rtl/scl_clk_gen_chk.sv
module scl_clk_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic scl_pull_low,
  input logic scl_level,
  input logic low_start,
  input logic drive_pt,
  input logic high_start,
  input logic sample_pt
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_pull_low && !low_start && !drive_pt && !high_start && !sample_pt)); // R1

  AST_PULL_OPENS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull_low) |-> low_start); // R9

  AST_START_WHILE_PULLED: assert property (@(posedge clk) disable iff (!rst_n)
    low_start |-> scl_pull_low); // R9

  AST_HIGH_AFTER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    high_start |-> (scl_level && !scl_pull_low)); // R7

  AST_LOW_ENDS_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_pull_low) && $past(en)) |-> !$past(scl_level)); // R5

  AST_STROBES_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({low_start, high_start}) && !(drive_pt && sample_pt)); // R9
endmodule

bind scl_clk_gen scl_clk_gen_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en          (clk_ctl[5]),
  .scl_pull_low(scl_pull_low),
  .scl_level   (scl_level),
  .low_start   (low_start),
  .drive_pt    (drive_pt),
  .high_start  (high_start),
  .sample_pt   (sample_pt)
);

// File: tb/test_scl_clk_gen.sv
module test_scl_clk_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] clk_ctl;
  logic [5:0] clk_ext;
  logic [3:0] freq_sel;
  logic       scl_in, sda_in, hold;
  logic       scl_pull_low, scl_level, sda_level;
  logic       low_start, drive_pt, high_start, sample_pt;

  int  nchk  = 0;
  int  nfail = 0;
  bit  done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // open-drain loopback with optional slave stretch
  assign scl_in = ~(scl_pull_low | hold);

  scl_clk_gen i_scl_clk_gen (
    .clk(clk), .rst_n(rst_n), .clk_ctl(clk_ctl), .clk_ext(clk_ext),
    .freq_sel(freq_sel), .scl_in(scl_in), .sda_in(sda_in),
    .scl_pull_low(scl_pull_low), .scl_level(scl_level), .sda_level(sda_level),
    .low_start(low_start), .drive_pt(drive_pt), .high_start(high_start),
    .sample_pt(sample_pt)
  );

  task automatic chk(input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int f_eff(input int f);
    return (f == 0) ? 1 : f;
  endfunction

  function automatic int exp_n(input bit fast, input int f, input int ext, input int lo);
    if (!fast && f <= 1) return lo + 65;
    return ext * 32 + lo + 1;
  endfunction

  function automatic int exp_low(input bit fast, input int f, input int ext, input int lo);
    return exp_n(fast, f, ext, lo) + 1;
  endfunction

  function automatic int exp_high(input bit fast, input int f, input int ext, input int lo);
    int n = exp_n(fast, f, ext, lo);
    return fast ? (n / 2 + 1) : (n + 1);
  endfunction

  task automatic measure(input int stretch, output int lw, output int dpos,
                         output int hw, output int hspos, output int sppos);
    int guard = 0;
    while (!low_start && guard < 5000) begin @(negedge clk); guard++; end
    lw = 0; dpos = -1;
    if (stretch > 0) hold = 1'b1;
    while (scl_pull_low) begin
      if (drive_pt) dpos = lw;
      lw++;
      @(negedge clk);
    end
    hw = 0; hspos = -1; sppos = -1;
    while (!scl_pull_low) begin
      if (hw == stretch) hold = 1'b0;
      if (high_start) hspos = hw;
      if (sample_pt) sppos = hw;
      hw++;
      @(negedge clk);
    end
  endtask

  task automatic run_cfg(input bit fast, input int f, input int ext, input int lo,
                         input int stretch, input int periods, input string req);
    int lw, dpos, hw, hspos, sppos, ll, hl, fe, elw;
    @(negedge clk);
    clk_ctl[5] = 1'b0;
    repeat (24) @(negedge clk);
    clk_ctl  = {fast, 1'b0, lo[4:0]};
    clk_ext  = ext[5:0];
    freq_sel = f[3:0];
    repeat (2) @(negedge clk);
    clk_ctl[5] = 1'b1;
    @(negedge clk);
    ll  = exp_low(fast, f, ext, lo);
    hl  = exp_high(fast, f, ext, lo);
    fe  = f_eff(f);
    elw = (ll > fe + 2) ? ll : fe + 2;
    for (int p = 0; p < periods; p++) begin
      measure(stretch, lw, dpos, hw, hspos, sppos);
      chk({req, "/R5 pull-low width"}, lw, elw);
      chk({req, "/R6 released width"}, hw, fe + 2 + stretch + hl);
      chk("R9 drive point index", dpos, ll / 2);
      chk("R7 high start after release", hspos, fe + 2 + stretch);
      chk("R11 sample point index", sppos, fe + 2 + stretch + hl / 2);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R10 watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int seed;
    bit fast;
    int f, ext, lo, st;
    string req;
    rst_n = 1'b0; clk_ctl = '0; clk_ext = '0; freq_sel = 4'd2;
    sda_in = 1'b1; hold = 1'b0;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    chk("R1 reset pull", int'(scl_pull_low), 0);
    chk("R1 reset strobes", int'({low_start, drive_pt, high_start, sample_pt}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 disabled pull", int'(scl_pull_low), 0);
    chk("R1 scl level idle", int'(scl_level), 1);
    chk("R1 sda level idle", int'(sda_level), 1);

    // directed corner cases
    run_cfg(1'b0, 3, 1, 4, 0, 2, "R2");     // N=37
    run_cfg(1'b0, 1, 5, 3, 0, 2, "R3");     // ext ignored, N=68
    run_cfg(1'b0, 0, 2, 0, 0, 1, "R3");     // freq 0 acts as 1
    run_cfg(1'b1, 11, 2, 9, 0, 2, "R4");    // N=74
    run_cfg(1'b1, 1, 0, 0, 0, 2, "R4");     // N=1, minimal phases
    run_cfg(1'b1, 8, 0, 1, 0, 2, "R4");     // low extended by filter
    run_cfg(1'b0, 4, 0, 20, 5, 2, "R7");    // stretched
    run_cfg(1'b1, 2, 1, 7, 13, 2, "R7");

    // random configurations
    for (int i = 0; i < 24; i++) begin
      fast = 1'($urandom % 2);
      f    = 1 + int'($urandom % 11);
      ext  = int'($urandom % 4);
      lo   = int'($urandom % 32);
      st   = ($urandom % 3 == 0) ? int'($urandom % 20) : 0;
      req  = fast ? "R4" : ((f <= 1) ? "R3" : "R2");
      run_cfg(fast, f, ext, lo, st, 2, req);
    end

    // R10: disable in the middle of a low phase, then re-enable
    run_cfg(1'b0, 2, 0, 30, 0, 1, "R2");
    repeat (5) @(negedge clk);
    chk("R10 running before disable", int'(scl_pull_low), 1);
    clk_ctl[5] = 1'b0;
    @(negedge clk);
    chk("R10 released after disable", int'(scl_pull_low), 0);
    for (int k = 0; k < 10; k++) begin
      if (scl_pull_low || low_start || high_start || sample_pt || drive_pt) begin
        chk("R1 quiet while disabled", 1, 0);
      end
      @(negedge clk);
    end
    chk("R1 quiet while disabled", 0, 0);
    clk_ctl[5] = 1'b1;
    @(negedge clk);
    chk("R10 fresh low_start", int'(low_start), 1);
    chk("R10 pulled after enable", int'(scl_pull_low), 1);

    // R8: filter length on SDA with F=6
    clk_ctl[5] = 1'b0;
    freq_sel = 4'd6;
    repeat (20) @(negedge clk);
    sda_in = 1'b0;
    repeat (5) @(negedge clk);
    sda_in = 1'b1;
    for (int k = 0; k < 15; k++) begin
      if (!sda_level) chk("R8 short pulse filtered", 0, 1);
      @(negedge clk);
    end
    chk("R8 short pulse filtered", int'(sda_level), 1);
    sda_in = 1'b0;
    repeat (6) @(negedge clk);
    chk("R8 level held before F+1", int'(sda_level), 1);
    @(negedge clk);
    chk("R8 level accepted at F+1", int'(sda_level), 0);
    sda_in = 1'b1;
    repeat (10) @(negedge clk);
    chk("R8 level returns high", int'(sda_level), 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule